// File: doc/BRIEF.md
# Firmware-OS Event Handshake Registers

This block holds three signalling channels through which two software agents, platform firmware and the operating system, hand events to each other. Each channel has a release bit that one side sets, a status bit that the other side acknowledges, and an enable bit that decides whether a pending release raises an interrupt. Setting a release bit also marks its partner status bit. Acknowledging the status bit also withdraws the release. Each pair therefore works as a linked semaphore.

The firmware-to-OS channel and the bus-master-activity channel drive a level system-control interrupt (`sci`). The OS-to-firmware channel drives a level system-management interrupt (`smi`). Each agent has its own write port, with a byte-enable per lane, and a read port that shows its own register. Both ports can write in the same cycle. Both interrupt outputs are registered.

Top module: `evt_handshake`

## Requirements
- R1: After a synchronous active-low reset, every bit of both registers reads 0, and `sci` and `smi` are 0.
- R2: A firmware write with 1 in firmware-register bit 8 (lane 1) sets the firmware-to-OS release bit. It also sets the OS-side global status bit, OS-register bit 0. Writing 0 there changes nothing.
- R3: An OS write with 1 in OS-register bit 0 (lane 0) clears that status bit and also clears firmware bit 8. Writing 0 there changes nothing.
- R4: `sci` is 1 in the cycle after firmware bit 8 and the OS-side enable (OS-register bit 1) are both 1.
- R5: An OS write with 1 in OS-register bit 8 sets the OS-to-firmware release bit and firmware-register bit 0 (firmware status). A firmware write with 1 in bit 0 clears both. Zero writes to either bit are ignored.
- R6: `smi` follows, one cycle later, the AND of OS bit 8 and the firmware enable (firmware-register bit 1).
- R7: A firmware write with 1 in firmware-register bit 16 (lane 2) sets the bus-master control bit and the bus-master status bit, OS-register bit 16. An OS write with 1 in OS bit 16 clears both. Zero writes are ignored.
- R8: `sci` is also 1 in the cycle after firmware bit 16 and the bus-master enable (OS-register bit 17) are both 1. `sci` is the OR of both sources and is 0 when neither holds.
- R9: The three enable bits (OS bit 1, OS bit 17, firmware bit 1) are plain read/write bits and read back the last value written.
- R10: When a set and a clear of the same linked pair arrive in the same cycle, from the two ports, the clear wins.
- R11: A byte lane whose enable is 0 is not written. Every bit in that lane keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_we | input | 1 | OS-port write strobe |
| os_be | input | DATA_W/8 | OS-port byte enables |
| os_wd | input | DATA_W | OS-port write data |
| os_rd | output | DATA_W | OS register read data |
| fw_we | input | 1 | Firmware-port write strobe |
| fw_be | input | DATA_W/8 | Firmware-port byte enables |
| fw_wd | input | DATA_W | Firmware-port write data |
| fw_rd | output | DATA_W | Firmware register read data |
| sci | output | 1 | System-control interrupt, registered level |
| smi | output | 1 | System-management interrupt, registered level |

## Verification
The release bit and the status bit of a pair are both readable. A pair that drifts apart, or a clear that loses to a set, shows up on the read ports right after the write edge. A wrong enable or a broken source term shows up on `sci` or `smi` exactly one cycle after the read ports show the condition. A missing register stage shows up as an interrupt that arrives one cycle early. Because every channel state is visible, each fault appears within two cycles of the write that exposes it.

// File: rtl/evhs_pkg.sv
package evhs_pkg;
   localparam int NCH      = 3;
   localparam int CH_F2O   = 0;
   localparam int CH_O2F   = 1;
   localparam int CH_BM    = 2;
   // OS register layout
   localparam int OS_GSTS  = 0;
   localparam int OS_GEN   = 1;
   localparam int OS_REL   = 8;
   localparam int OS_BMSTS = 16;
   localparam int OS_BMEN  = 17;
   // firmware register layout
   localparam int FW_STS   = 0;
   localparam int FW_EN    = 1;
   localparam int FW_REL   = 8;
   localparam int FW_BMCTL = 16;
   localparam int MIN_W    = 24;
   // channel-to-interrupt routing
   localparam logic [NCH-1:0] SCI_SRC = 3'b101;
   localparam logic [NCH-1:0] SMI_SRC = 3'b010;
endpackage

// File: rtl/evhs_chan.sv
module evhs_chan #(
   parameter bit EN_RST = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rel_set,
   input  logic sts_clr,
   input  logic en_we,
   input  logic en_wd,
   output logic rel,
   output logic sts,
   output logic en,
   output logic evt
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rel <= 1'b0;
         sts <= 1'b0;
      end else if (sts_clr) begin
         rel <= 1'b0;
         sts <= 1'b0;
      end else if (rel_set) begin
         rel <= 1'b1;
         sts <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     en <= EN_RST;
      else if (en_we) en <= en_wd;
   end

   assign evt = rel & en;
endmodule

// File: rtl/evhs_irq.sv
module evhs_irq #(
   parameter int              NCH      = 3,
   parameter logic [NCH-1:0]  SCI_MASK = '0,
   parameter logic [NCH-1:0]  SMI_MASK = '0,
   parameter bit              OUT_REG  = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] evt,
   output logic           sci,
   output logic           smi
);
   logic sci_d, smi_d;
   assign sci_d = |(evt & SCI_MASK);
   assign smi_d = |(evt & SMI_MASK);

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sci <= 1'b0;
               smi <= 1'b0;
            end else begin
               sci <= sci_d;
               smi <= smi_d;
            end
         end
      end else begin : g_comb
         assign sci = sci_d;
         assign smi = smi_d;
      end
   endgenerate
endmodule

// File: rtl/evt_handshake.sv
module evt_handshake
   import evhs_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit OUT_REG = 1'b1,
   localparam int BE_W   = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_we,
   input  logic [BE_W-1:0]   os_be,
   input  logic [DATA_W-1:0] os_wd,
   output logic [DATA_W-1:0] os_rd,
   input  logic              fw_we,
   input  logic [BE_W-1:0]   fw_be,
   input  logic [DATA_W-1:0] fw_wd,
   output logic [DATA_W-1:0] fw_rd,
   output logic              sci,
   output logic              smi
);
   generate
      if (DATA_W < MIN_W || (DATA_W % 8) != 0) begin : g_bad_width
         $error("evt_handshake: DATA_W must be a multiple of 8 and at least %0d", MIN_W);
      end
   endgenerate

   function automatic logic hit(input logic we, input logic [BE_W-1:0] be,
                                input logic [DATA_W-1:0] wd, input int pos);
      return we & be[pos/8] & wd[pos];
   endfunction

   function automatic logic lane(input logic we, input logic [BE_W-1:0] be,
                                 input int pos);
      return we & be[pos/8];
   endfunction

   logic [NCH-1:0] rel_set, sts_clr, en_we, en_wd;
   logic [NCH-1:0] rel, sts, en, evt;

   always_comb begin
      rel_set[CH_F2O] = hit(fw_we, fw_be, fw_wd, FW_REL);
      sts_clr[CH_F2O] = hit(os_we, os_be, os_wd, OS_GSTS);
      en_we[CH_F2O]   = lane(os_we, os_be, OS_GEN);
      en_wd[CH_F2O]   = os_wd[OS_GEN];

      rel_set[CH_O2F] = hit(os_we, os_be, os_wd, OS_REL);
      sts_clr[CH_O2F] = hit(fw_we, fw_be, fw_wd, FW_STS);
      en_we[CH_O2F]   = lane(fw_we, fw_be, FW_EN);
      en_wd[CH_O2F]   = fw_wd[FW_EN];

      rel_set[CH_BM]  = hit(fw_we, fw_be, fw_wd, FW_BMCTL);
      sts_clr[CH_BM]  = hit(os_we, os_be, os_wd, OS_BMSTS);
      en_we[CH_BM]    = lane(os_we, os_be, OS_BMEN);
      en_wd[CH_BM]    = os_wd[OS_BMEN];
   end

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         evhs_chan #(.EN_RST(1'b0)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .rel_set (rel_set[c]),
            .sts_clr (sts_clr[c]),
            .en_we   (en_we[c]),
            .en_wd   (en_wd[c]),
            .rel     (rel[c]),
            .sts     (sts[c]),
            .en      (en[c]),
            .evt     (evt[c])
         );
      end
   endgenerate

   always_comb begin
      os_rd           = '0;
      os_rd[OS_GSTS]  = sts[CH_F2O];
      os_rd[OS_GEN]   = en[CH_F2O];
      os_rd[OS_REL]   = rel[CH_O2F];
      os_rd[OS_BMSTS] = sts[CH_BM];
      os_rd[OS_BMEN]  = en[CH_BM];

      fw_rd           = '0;
      fw_rd[FW_STS]   = sts[CH_O2F];
      fw_rd[FW_EN]    = en[CH_O2F];
      fw_rd[FW_REL]   = rel[CH_F2O];
      fw_rd[FW_BMCTL] = rel[CH_BM];
   end

   evhs_irq #(
      .NCH      (NCH),
      .SCI_MASK (SCI_SRC),
      .SMI_MASK (SMI_SRC),
      .OUT_REG  (OUT_REG)
   ) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt),
      .sci   (sci),
      .smi   (smi)
   );
endmodule

// File: rtl/evhs_chk.sv
module evhs_chk
   import evhs_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit OUT_REG = 1'b1,
   localparam int BE_W   = DATA_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              os_we,
   input logic [BE_W-1:0]   os_be,
   input logic [DATA_W-1:0] os_wd,
   input logic [DATA_W-1:0] os_rd,
   input logic              fw_we,
   input logic [BE_W-1:0]   fw_be,
   input logic [DATA_W-1:0] fw_wd,
   input logic [DATA_W-1:0] fw_rd,
   input logic              sci,
   input logic              smi
);
   logic f2o_set, f2o_clr, o2f_set, o2f_clr, bm_set, bm_clr;
   assign f2o_set = fw_we & fw_be[FW_REL/8]   & fw_wd[FW_REL];
   assign f2o_clr = os_we & os_be[OS_GSTS/8]  & os_wd[OS_GSTS];
   assign o2f_set = os_we & os_be[OS_REL/8]   & os_wd[OS_REL];
   assign o2f_clr = fw_we & fw_be[FW_STS/8]   & fw_wd[FW_STS];
   assign bm_set  = fw_we & fw_be[FW_BMCTL/8] & fw_wd[FW_BMCTL];
   assign bm_clr  = os_we & os_be[OS_BMSTS/8] & os_wd[OS_BMSTS];

   assert_f2o_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (f2o_set && !f2o_clr) |=> (os_rd[OS_GSTS] && fw_rd[FW_REL]));

   // R10: the clear wins even when a set arrives in the same cycle
   assert_f2o_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      f2o_clr |=> (!os_rd[OS_GSTS] && !fw_rd[FW_REL]));

   assert_o2f_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      o2f_clr |=> (!os_rd[OS_REL] && !fw_rd[FW_STS]));

   assert_o2f_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (o2f_set && !o2f_clr) |=> (os_rd[OS_REL] && fw_rd[FW_STS]));

   assert_bm_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bm_clr |=> (!os_rd[OS_BMSTS] && !fw_rd[FW_BMCTL]));

   assert_bm_lane_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!(os_we && os_be[OS_BMEN/8])) |=> $stable(os_rd[OS_BMEN]));

   generate
      if (OUT_REG) begin : g_irq_chk
         assert_sci_f2o_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (fw_rd[FW_REL] && os_rd[OS_GEN]) |=> sci);
         assert_sci_bm_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (fw_rd[FW_BMCTL] && os_rd[OS_BMEN]) |=> sci);
         assert_sci_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!(fw_rd[FW_REL] && os_rd[OS_GEN]) && !(fw_rd[FW_BMCTL] && os_rd[OS_BMEN]))
            |=> !sci);
         assert_smi_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (os_rd[OS_REL] && fw_rd[FW_EN]) |=> smi);
         assert_smi_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !(os_rd[OS_REL] && fw_rd[FW_EN]) |=> !smi);
      end
   endgenerate
endmodule

bind evt_handshake evhs_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .os_we (os_we),
   .os_be (os_be),
   .os_wd (os_wd),
   .os_rd (os_rd),
   .fw_we (fw_we),
   .fw_be (fw_be),
   .fw_wd (fw_wd),
   .fw_rd (fw_rd),
   .sci   (sci),
   .smi   (smi)
);

// File: tb/tb_evt_handshake.sv
module tb_evt_handshake;
   localparam int CLK_P  = 10;
   localparam int DATA_W = 32;
   localparam int BE_W   = DATA_W / 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              os_we = 1'b0, fw_we = 1'b0;
   logic [BE_W-1:0]   os_be = '0, fw_be = '0;
   logic [DATA_W-1:0] os_wd = '0, fw_wd = '0;
   logic [DATA_W-1:0] os_rd, fw_rd;
   logic              sci, smi;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   evt_handshake #(.DATA_W(DATA_W)) dut (
      .clk(clk), .rst_n(rst_n),
      .os_we(os_we), .os_be(os_be), .os_wd(os_wd), .os_rd(os_rd),
      .fw_we(fw_we), .fw_be(fw_be), .fw_wd(fw_wd), .fw_rd(fw_rd),
      .sci(sci), .smi(smi)
   );

   task automatic chk(input string req, input logic [DATA_W-1:0] act,
                      input logic [DATA_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic chk_regs(input string req, input logic [DATA_W-1:0] os_e,
                           input logic [DATA_W-1:0] fw_e);
      chk({req, " os_rd"}, os_rd, os_e);
      chk({req, " fw_rd"}, fw_rd, fw_e);
   endtask

   // each write task returns at the negedge after the write edge
   task automatic os_wr(input logic [BE_W-1:0] be, input logic [DATA_W-1:0] d);
      @(negedge clk);
      os_we = 1'b1; os_be = be; os_wd = d;
      @(negedge clk);
      os_we = 1'b0; os_be = '0; os_wd = '0;
   endtask

   task automatic fw_wr(input logic [BE_W-1:0] be, input logic [DATA_W-1:0] d);
      @(negedge clk);
      fw_we = 1'b1; fw_be = be; fw_wd = d;
      @(negedge clk);
      fw_we = 1'b0; fw_be = '0; fw_wd = '0;
   endtask

   task automatic both_wr(input logic [BE_W-1:0] obe, input logic [DATA_W-1:0] od,
                          input logic [BE_W-1:0] fbe, input logic [DATA_W-1:0] fd);
      @(negedge clk);
      os_we = 1'b1; os_be = obe; os_wd = od;
      fw_we = 1'b1; fw_be = fbe; fw_wd = fd;
      @(negedge clk);
      os_we = 1'b0; os_be = '0; os_wd = '0;
      fw_we = 1'b0; fw_be = '0; fw_wd = '0;
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk_regs("R1 reset", 32'h0, 32'h0);
      chk("R1 sci reset", sci, 0);
      chk("R1 smi reset", smi, 0);
   endtask

   task automatic t_fw_to_os();
      fw_wr(4'b0010, 32'h100);
      chk_regs("R2 fw release sets status", 32'h1, 32'h100);
      fw_wr(4'b1111, 32'h0);
      chk_regs("R2 zero write ignored", 32'h1, 32'h100);
      os_wr(4'b0001, 32'h2);
      chk_regs("R9 os enable readback", 32'h3, 32'h100);
      chk("R4 sci not yet (registered)", sci, 0);
      idle();
      chk("R4 sci raised", sci, 1);
      os_wr(4'b0001, 32'h2);
      chk_regs("R3 zero to status ignored", 32'h3, 32'h100);
      os_wr(4'b0001, 32'h3);
      chk_regs("R3 status clear drops release", 32'h2, 32'h0);
      idle();
      chk("R4 sci dropped", sci, 0);
   endtask

   task automatic t_os_to_fw();
      os_wr(4'b0010, 32'h100);
      chk_regs("R5 os release sets fw status", 32'h102, 32'h1);
      fw_wr(4'b0001, 32'h2);
      chk_regs("R9 fw enable readback", 32'h102, 32'h3);
      chk("R6 smi not yet", smi, 0);
      idle();
      chk("R6 smi raised", smi, 1);
      chk("R6 sci unaffected", sci, 0);
      fw_wr(4'b0001, 32'h3);
      chk_regs("R5 fw status clear drops release", 32'h2, 32'h2);
      idle();
      chk("R6 smi dropped", smi, 0);
   endtask

   task automatic t_bus_master();
      os_wr(4'b0100, 32'h2_0000);
      chk_regs("R9 bm enable readback", 32'h2_0002, 32'h2);
      fw_wr(4'b0100, 32'h1_0000);
      chk_regs("R7 bm control sets bm status", 32'h3_0002, 32'h1_0002);
      idle();
      chk("R8 sci from bus master", sci, 1);
      os_wr(4'b0100, 32'h2_0000);
      chk_regs("R7 zero to bm status ignored", 32'h3_0002, 32'h1_0002);
      os_wr(4'b0100, 32'h3_0000);
      chk_regs("R7 bm status clear drops control", 32'h2_0002, 32'h2);
      idle();
      chk("R8 sci quiet", sci, 0);
   endtask

   task automatic t_collide();
      both_wr(4'b0010, 32'h100, 4'b0001, 32'h3);
      chk_regs("R10 o2f clear wins", 32'h2_0002, 32'h2);
      both_wr(4'b0001, 32'h3, 4'b0010, 32'h100);
      chk_regs("R10 f2o clear wins", 32'h2_0002, 32'h2);
      both_wr(4'b0100, 32'h3_0000, 4'b0100, 32'h1_0000);
      chk_regs("R10 bm clear wins", 32'h2_0002, 32'h2);
      idle();
      chk("R10 no sci after collisions", sci, 0);
      chk("R10 no smi after collisions", smi, 0);
   endtask

   task automatic t_byte_enable();
      os_wr(4'b0000, 32'hFFFF_FFFF);
      chk_regs("R11 os lanes disabled", 32'h2_0002, 32'h2);
      fw_wr(4'b0000, 32'hFFFF_FFFF);
      chk_regs("R11 fw lanes disabled", 32'h2_0002, 32'h2);
      os_wr(4'b0001, 32'h0);
      chk_regs("R11 only lane 0 written", 32'h2_0000, 32'h2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_fw_to_os();
      t_os_to_fw();
      t_bus_master();
      t_collide();
      t_byte_enable();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule